// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

This block turns up to eight synchronized input pins into individual interrupt requests for a parent interrupt controller. Output `irq_o[k]` is intended for parent line 32+k. Each channel works in one of two ways, chosen per channel. It can latch rising and falling transitions until software acknowledges them. It can also follow a qualified pin level, with a programmable active polarity.

Software reaches the block over a small 32-bit register bus. The rising-edge enable and the falling-edge enable can each be written whole. Each also has two alias addresses. One alias sets only the bits written as 1 and the other clears only those bits. This lets a driver mask or unmask one channel without a read-modify-write sequence. In level mode the falling-enable bit is reused as the polarity select, so the same register set serves both modes. Separate rising and falling status registers can be read. A combined status register shows each channel's interrupt output, and writing ones to it acknowledges edges.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset every readable register reads 0 and `irq_o` is 0. Every channel is then level-sensitive with its enables off.
- R2: The registers at 0x00 (mode), 0x04 (rising/level enable) and 0x10 (falling enable/polarity) are written whole and read back; bits above the channel count read 0. Read data appears on `bus_rdata` in the cycle after the read request. The alias addresses 0x08, 0x0C, 0x14 and 0x18 read 0, as does any address outside the map.
- R3: A write to 0x08 sets the rising enable bits written as 1. A write to 0x14 does the same for the falling enable. Bits written as 0 keep their value.
- R4: A write to 0x0C clears the rising enable bits written as 1. A write to 0x18 does the same for the falling enable. Bits written as 0 keep their value.
- R5: A mode bit of 0 selects level sensitivity. In that mode `irq_o[k]` is rising-enable[k] AND (pin[k] == falling-enable[k]), so a falling-enable bit of 1 means active high and 0 means active low. A pin change shows on `irq_o` after two rising clock edges.
- R6: A mode bit of 1 selects edge sensitivity. In that mode a pin transition from 0 to 1 sets the channel's bit in the rising status register (0x1C). A transition from 1 to 0 sets its bit in the falling status register (0x20). The bit is set on the third rising clock edge after the pin change, whatever the enables are. Transitions seen in level mode set nothing.
- R7: In edge mode `irq_o[k]` = (rising status AND rising enable) OR (falling status AND falling enable). Register 0x24 reads back `irq_o` in both modes.
- R8: Writing ones to 0x24 clears both latched status bits of those channels. Writing ones to 0x1C clears only rising status bits, and writing ones to 0x20 clears only falling status bits. Bits written as 0 are unaffected.
- R9: In level mode the combined status is not latched. Writing ones to 0x24 does not change what 0x24 reads or what `irq_o` shows.
- R10: When a status bit is to be set by an edge and cleared by a write on the same clock edge, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | NCH | Asynchronous pins, one per channel |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request, 0 otherwise |
| irq_o | output | NCH | Per-channel interrupt to the parent controller |

## Verification
Each result has its own latency. A register write takes effect at the clock edge that samples it. Read data is registered one edge after the request. A level result reaches `irq_o` two edges after a pin change, and an edge status bit sets on the third edge. The bench drives every input on the falling clock edge and counts the rising edges in its own tasks. Level sweeps are sampled after exactly two edges, and edge sweeps after four edges, so each transition has fully settled. Separate tests sample one edge before each deadline and again at the deadline, to show that the timing is exact. The same-edge set/clear test places the acknowledge write on precisely the third edge after the pin change.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE    = 8'h00,
    A_REN     = 8'h04,
    A_REN_SET = 8'h08,
    A_REN_CLR = 8'h0C,
    A_FEN     = 8'h10,
    A_FEN_SET = 8'h14,
    A_FEN_CLR = 8'h18,
    A_RST     = 8'h1C,
    A_FST     = 8'h20,
    A_IST     = 8'h24
  } reg_addr_e;

  // set-alias update: only ones in the mask take effect
  function automatic logic [REG_W-1:0] f_set(input logic [REG_W-1:0] cur,
                                             input logic [REG_W-1:0] msk);
    return cur | msk;
  endfunction

  // clear-alias update
  function automatic logic [REG_W-1:0] f_clr(input logic [REG_W-1:0] cur,
                                             input logic [REG_W-1:0] msk);
    return cur & ~msk;
  endfunction

  // latched status: a new event wins over an acknowledge
  function automatic logic f_latch(input logic cur, input logic set,
                                   input logic ack);
    return set | (cur & ~ack);
  endfunction

  // level qualification: enable AND pin matches polarity
  function automatic logic f_level_hit(input logic en, input logic pol,
                                       input logic pin);
    return en & ~(pin ^ pol);
  endfunction

  // edge qualification
  function automatic logic f_edge_hit(input logic rst, input logic fst,
                                      input logic ren, input logic fen);
    return (rst & ren) | (fst & fen);
  endfunction
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  output logic [NCH-1:0] sync_o,
  output logic [NCH-1:0] rise_evt_o,
  output logic [NCH-1:0] fall_evt_o
);
  logic [NCH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o     = sync_q;
  assign rise_evt_o = sync_q & ~prev_q;
  assign fall_evt_o = ~sync_q & prev_q;
endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs
  import pinirq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [NCH-1:0]    rise_st_i,
  input  logic [NCH-1:0]    fall_st_i,
  input  logic [NCH-1:0]    ist_i,
  output logic [NCH-1:0]    mode_o,
  output logic [NCH-1:0]    ren_o,
  output logic [NCH-1:0]    fen_o,
  output logic [NCH-1:0]    ack_rise_o,
  output logic [NCH-1:0]    ack_fall_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic             wr_s, rd_s;
  logic [NCH-1:0]   wmask;
  logic [NCH-1:0]   mode_q, ren_q, fen_q;
  logic [REG_W-1:0] rd_mux;

  assign wr_s  = bus_en & bus_we;
  assign rd_s  = bus_en & ~bus_we;
  assign wmask = bus_wdata[NCH-1:0];

  generate
    if (NCH < REG_W) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^bus_wdata[REG_W-1:NCH];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
    end else if (wr_s) begin
      case (bus_addr)
        A_MODE:    mode_q <= wmask;
        A_REN:     ren_q  <= wmask;
        A_REN_SET: ren_q  <= NCH'(f_set(REG_W'(ren_q), REG_W'(wmask)));
        A_REN_CLR: ren_q  <= NCH'(f_clr(REG_W'(ren_q), REG_W'(wmask)));
        A_FEN:     fen_q  <= wmask;
        A_FEN_SET: fen_q  <= NCH'(f_set(REG_W'(fen_q), REG_W'(wmask)));
        A_FEN_CLR: fen_q  <= NCH'(f_clr(REG_W'(fen_q), REG_W'(wmask)));
        default:   ;
      endcase
    end
  end

  // acknowledge strobes towards the channel status flops
  always_comb begin
    ack_rise_o = '0;
    ack_fall_o = '0;
    if (wr_s) begin
      if (bus_addr == A_RST || bus_addr == A_IST) ack_rise_o = wmask;
      if (bus_addr == A_FST || bus_addr == A_IST) ack_fall_o = wmask;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  rd_mux = REG_W'(mode_q);
      A_REN:   rd_mux = REG_W'(ren_q);
      A_FEN:   rd_mux = REG_W'(fen_q);
      A_RST:   rd_mux = REG_W'(rise_st_i);
      A_FST:   rd_mux = REG_W'(fall_st_i);
      A_IST:   rd_mux = REG_W'(ist_i);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= rd_s ? rd_mux : '0;
  end

  assign mode_o = mode_q;
  assign ren_o  = ren_q;
  assign fen_o  = fen_q;
endmodule

// File: rtl/pinirq_chan.sv
module pinirq_chan
  import pinirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic edge_mode_i,
  input  logic ren_i,
  input  logic fen_i,
  input  logic sync_i,
  input  logic rise_evt_i,
  input  logic fall_evt_i,
  input  logic ack_rise_i,
  input  logic ack_fall_i,
  output logic rise_st_o,
  output logic fall_st_o,
  output logic irq_o
);
  logic rise_q, fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= f_latch(rise_q, edge_mode_i & rise_evt_i, ack_rise_i);
      fall_q <= f_latch(fall_q, edge_mode_i & fall_evt_i, ack_fall_i);
    end
  end

  assign rise_st_o = rise_q;
  assign fall_st_o = fall_q;
  assign irq_o = edge_mode_i ? f_edge_hit(rise_q, fall_q, ren_i, fen_i)
                             : f_level_hit(ren_i, fen_i, sync_i);
endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
  import pinirq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pin_i,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    irq_o
);
  logic [NCH-1:0] pin_sync, rise_evt, fall_evt;
  logic [NCH-1:0] mode_q, ren_q, fen_q;
  logic [NCH-1:0] ack_rise, ack_fall;
  logic [NCH-1:0] rise_st, fall_st, irq_vec;

  pinirq_sync #(.NCH(NCH)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin_i),
    .sync_o     (pin_sync),
    .rise_evt_o (rise_evt),
    .fall_evt_o (fall_evt)
  );

  pinirq_regs #(.NCH(NCH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .rise_st_i  (rise_st),
    .fall_st_i  (fall_st),
    .ist_i      (irq_vec),
    .mode_o     (mode_q),
    .ren_o      (ren_q),
    .fen_o      (fen_q),
    .ack_rise_o (ack_rise),
    .ack_fall_o (ack_fall),
    .rdata_o    (bus_rdata)
  );

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_ch
      pinirq_chan u_ch (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_mode_i (mode_q[k]),
        .ren_i       (ren_q[k]),
        .fen_i       (fen_q[k]),
        .sync_i      (pin_sync[k]),
        .rise_evt_i  (rise_evt[k]),
        .fall_evt_i  (fall_evt[k]),
        .ack_rise_i  (ack_rise[k]),
        .ack_fall_i  (ack_fall[k]),
        .rise_st_o   (rise_st[k]),
        .fall_st_o   (fall_st[k]),
        .irq_o       (irq_vec[k])
      );
    end
  endgenerate

  assign irq_o = irq_vec;
endmodule

// File: rtl/pinirq_ctrl_chk.sv
module pinirq_ctrl_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_en,
  input logic           bus_we,
  input logic [7:0]     bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [31:0]    bus_rdata,
  input logic [NCH-1:0] irq_o,
  input logic [NCH-1:0] mode_q,
  input logic [NCH-1:0] ren_q,
  input logic [NCH-1:0] fen_q,
  input logic [NCH-1:0] rise_st,
  input logic [NCH-1:0] rise_evt
);
  // R3
  ren_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == 8'h08)
      |=> (ren_q == ($past(ren_q) | $past(bus_wdata[NCH-1:0]))));

  // R4
  fen_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == 8'h18)
      |=> (fen_q == ($past(fen_q) & ~$past(bus_wdata[NCH-1:0]))));

  // R2
  alias_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && (bus_addr == 8'h08 || bus_addr == 8'h0C ||
                           bus_addr == 8'h14 || bus_addr == 8'h18 ||
                           bus_addr > 8'h24))
      |=> (bus_rdata == 32'h0));

  // R6 / R10: an edge in edge mode always leaves its status bit set
  rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise_evt & mode_q))
      |=> ((rise_st & $past(rise_evt & mode_q)) == $past(rise_evt & mode_q)));

  // R6
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_st & ~$past(rise_st) & ~$past(rise_evt & mode_q)) == '0));

  // R7
  edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & mode_q & ~ren_q & ~fen_q) == '0));

  // R5
  level_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~mode_q & ~ren_q) == '0));
endmodule

bind pinirq_ctrl pinirq_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .mode_q    (mode_q),
  .ren_q     (ren_q),
  .fen_q     (fen_q),
  .rise_st   (rise_st),
  .rise_evt  (rise_evt)
);

// File: tb/pinirq_ctrl_tb.sv
module pinirq_ctrl_tb_top;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pin_i = '0;
  logic           bus_en = 1'b0;
  logic           bus_we = 1'b0;
  logic [7:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] irq_o;

  int total = 0;
  int bad = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #5 clk = ~clk;

  pinirq_ctrl #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    tick();
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] rnd8(inout logic [31:0] s);
    s = s * 32'd1103515245 + 32'd12345;
    return s[23:16];
  endfunction

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] r;
    logic [7:0] ren, fen, p0, p1, exp_r, exp_f;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a <= 'h24; a += 4) begin
      rd(8'(a), r);
      check($sformatf("R1 reset read 0x%0h", a), r, 32'h0);
    end
    check("R1 reset irq", 32'(irq_o), 32'h0);

    // R2: direct writes, width limit, aliases and unmapped read 0
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, r); check("R2 mode width", r, 32'hFF);
    wr(8'h00, 32'h0);         rd(8'h00, r); check("R2 mode zero", r, 32'h0);
    wr(8'h04, 32'h5A);        rd(8'h04, r); check("R2 ren direct", r, 32'h5A);
    wr(8'h10, 32'hC3);        rd(8'h10, r); check("R2 fen direct", r, 32'hC3);
    rd(8'h08, r); check("R2 alias 08 reads 0", r, 32'h0);
    rd(8'h18, r); check("R2 alias 18 reads 0", r, 32'h0);
    rd(8'h28, r); check("R2 unmapped reads 0", r, 32'h0);

    // R3 / R4: per-channel set and clear sweep
    wr(8'h04, 32'h0); wr(8'h10, 32'h0);
    ren = 8'h00; fen = 8'h00;
    for (int k = 0; k < NCH; k++) begin
      wr(8'h08, 32'(1 << k)); ren = ren | 8'(1 << k);
      rd(8'h04, r); check($sformatf("R3 ren set ch%0d", k), r, 32'(ren));
      wr(8'h14, 32'(1 << k)); fen = fen | 8'(1 << k);
      rd(8'h10, r); check($sformatf("R3 fen set ch%0d", k), r, 32'(fen));
    end
    wr(8'h08, 32'h0); rd(8'h04, r); check("R3 zero write keeps ren", r, 32'hFF);
    for (int k = 0; k < NCH; k += 2) begin
      wr(8'h0C, 32'(1 << k)); ren = ren & ~8'(1 << k);
      rd(8'h04, r); check($sformatf("R4 ren clr ch%0d", k), r, 32'(ren));
      wr(8'h18, 32'(3 << k)); fen = fen & ~8'(3 << k);
      rd(8'h10, r); check($sformatf("R4 fen clr ch%0d", k), r, 32'(fen));
    end
    wr(8'h18, 32'h0); rd(8'h10, r); check("R4 zero write keeps fen", r, 32'(fen));

    // R5: level timing (two edges)
    wr(8'h00, 32'h0); wr(8'h04, 32'hFF); wr(8'h10, 32'hFF);
    pin_i = 8'h00; tick(); tick();
    check("R5 active-high idle", 32'(irq_o), 32'h0);
    pin_i = 8'hFF; tick();
    check("R5 not yet after one edge", 32'(irq_o), 32'h0);
    tick();
    check("R5 asserted after two edges", 32'(irq_o), 32'hFF);

    // R5 / R7 / R9: level sweep
    for (int i = 0; i < 64; i++) begin
      ren = rnd8(lcg); fen = rnd8(lcg); p1 = rnd8(lcg);
      wr(8'h04, 32'(ren)); wr(8'h10, 32'(fen));
      pin_i = p1; tick(); tick();
      check($sformatf("R5 level irq it%0d", i), 32'(irq_o), 32'(ren & ~(p1 ^ fen)));
      if (i % 4 == 0) begin
        wr(8'h24, 32'hFF);
        rd(8'h24, r);
        check($sformatf("R9 level ist unaffected it%0d", i), r, 32'(ren & ~(p1 ^ fen)));
      end
    end
    rd(8'h1C, r); check("R6 no rise status in level mode", r, 32'h0);
    rd(8'h20, r); check("R6 no fall status in level mode", r, 32'h0);

    // R6: edge timing (third edge)
    pin_i = 8'h00; tick(); tick(); tick();
    wr(8'h00, 32'hFF); wr(8'h04, 32'hFF); wr(8'h10, 32'h00);
    wr(8'h24, 32'hFF);
    check("R7 edge idle", 32'(irq_o), 32'h0);
    pin_i = 8'h01; tick(); tick();
    check("R6 status not set at second edge", 32'(irq_o), 32'h0);
    tick();
    check("R6 status set at third edge", 32'(irq_o), 32'h01);

    // R10: edge and acknowledge on the same edge
    wr(8'h24, 32'hFF);
    pin_i = 8'h03; tick(); tick();
    wr(8'h24, 32'h02);
    rd(8'h1C, r); check("R10 set wins over clear", r & 32'h2, 32'h2);

    // R6 / R7: edge sweep
    wr(8'h24, 32'hFF);
    p0 = 8'h03;
    for (int i = 0; i < 32; i++) begin
      wr(8'h24, 32'hFF);
      ren = rnd8(lcg); fen = rnd8(lcg); p1 = rnd8(lcg);
      wr(8'h04, 32'(ren)); wr(8'h10, 32'(fen));
      pin_i = p1; tick(); tick(); tick(); tick();
      exp_r = p1 & ~p0; exp_f = ~p1 & p0;
      rd(8'h1C, r); check($sformatf("R6 rise status it%0d", i), r, 32'(exp_r));
      rd(8'h20, r); check($sformatf("R6 fall status it%0d", i), r, 32'(exp_f));
      check($sformatf("R7 edge irq it%0d", i), 32'(irq_o), 32'((exp_r & ren) | (exp_f & fen)));
      rd(8'h24, r); check($sformatf("R7 ist readback it%0d", i), r, 32'((exp_r & ren) | (exp_f & fen)));
      p0 = p1;
    end

    // R8: selective acknowledge
    wr(8'h24, 32'hFF);
    pin_i = 8'h00; tick(); tick(); tick(); tick();
    wr(8'h24, 32'hFF);
    pin_i = 8'hFF; tick(); tick(); tick(); tick();
    pin_i = 8'h00; tick(); tick(); tick(); tick();
    wr(8'h1C, 32'h0F);
    rd(8'h1C, r); check("R8 rise ack own", r, 32'hF0);
    rd(8'h20, r); check("R8 rise ack leaves fall", r, 32'hFF);
    wr(8'h20, 32'h30);
    rd(8'h20, r); check("R8 fall ack own", r, 32'hCF);
    wr(8'h24, 32'hC0);
    rd(8'h1C, r); check("R8 combined ack rise", r, 32'h30);
    rd(8'h20, r); check("R8 combined ack fall", r, 32'h0F);

    report();
  end
endmodule